// File: doc/BRIEF.md
# Rate-Adjustable Nanosecond Time Counter

This block keeps a free-running 40-bit nanosecond count for a precision time protocol clock. Every clock cycle is one 8 ns tick. On each tick the count advances by a fixed 8 ns step. A 32-bit sub-nanosecond accumulator trims that step. Software programs a signed fraction, and on each tick the fraction is added to or subtracted from the accumulator. A carry out of the accumulator lengthens that tick's step to 9 ns, and a borrow shortens it to 7 ns. The count therefore runs fast or slow by a precisely controlled ratio. A fraction magnitude M gives M·2^-32 ns per tick, so a trim of N parts per billion is N·2^26/1953125.

Software reaches the block through a small word-wide register port. Reading the sub-nanosecond word freezes a copy of the full count. The nanosecond low and high words read after it therefore come from one instant, even when the live count carries between the two reads. Reading the high word lets the view follow live time again. Time is loaded in two steps. A write to the low word only stages the value. The following high-word write commits the whole 40-bit value, clears the accumulator and drops any frozen view. The count moves only while the halt bit of the control word is clear, and it leaves reset halted.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count and the accumulator are zero, the rate word reads 0, the control word reads 0x8000_0000 (halted) and no frozen view is held.
- R2: The count and the accumulator advance only while control bit 31 (address 4) is 0. While it is 1, both hold their values. Only bit 31 of the control word is stored, and the other bits read as zero.
- R3: With rate bit 31 clear, each running tick adds the magnitude (rate bits 30:0) to the 32-bit accumulator. The count advances by 8, or by 9 when that addition carries out of bit 31.
- R4: With rate bit 31 set, each running tick subtracts the magnitude from the accumulator. The count advances by 8, or by 7 when that subtraction borrows.
- R5: The count wraps silently modulo 2^40.
- R6: Register addresses are 0 for the sub-ns accumulator, 1 for count bits 31:0, 2 for count bits 39:32 in bits 7:0 with bits 31:8 reading zero, 3 for the rate word (read back as written) and 4 for control. Read data appears on the cycle after the read strobe.
- R7: A read of address 0 freezes a copy of the count taken in that cycle. Later reads of addresses 1 and 2 return the frozen copy until the view is released.
- R8: A read of address 2 releases the frozen view, so the next read of address 1 shows live time.
- R9: A write to address 1 only stages the value and leaves the count untouched. A write to address 2 loads {wdata[7:0], staged word} on the next cycle, in place of that cycle's tick, even while halted. It also clears the accumulator and releases the frozen view.
- R10: Writes to address 0 have no effect, and reads of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one 8 ns tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_ns | output | 40 | Live nanosecond count |
| time_run | output | 1 | High while the counter advances |

## Verification
The embedded assertions check on every cycle that a running tick moves the count by 7, 8 or 9 ns modulo 2^40, and that a halted counter and its accumulator stay still. They also check that a load lands the committed value and clears the fraction, that a frozen copy holds until it is released, and that the unused upper bits of the high word read zero. Only the bench scenarios can show the exact carry and borrow cadence for a given fraction, that a coherent read pair matches the instant of the sub-ns read, and that the staged low word and writes to address 0 leave the count alone. The bench also drives random mixes of rate changes, loads, halts and reads, and compares every cycle against a model written from the requirements.

// File: rtl/ns_tc_pkg.sv
package ns_tc_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int FRAC_W   = DATA_W;
    localparam int TRIM_M_W = FRAC_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_SUBNS = 3'd0,
        REG_NSLO  = 3'd1,
        REG_NSHI  = 3'd2,
        REG_TRIM  = 3'd3,
        REG_CTRL  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic                neg;
        logic [TRIM_M_W-1:0] mag;
    } trim_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    // Decoded one-hot strobes for one bus request.
    typedef struct packed {
        logic rd_subns;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
        logic wr_trim;
        logic wr_ctrl;
    } bus_dec_t;

    function automatic bus_dec_t decode_req(bus_req_t req);
        bus_dec_t d;
        d.rd_subns = req.rd && (req.addr == REG_SUBNS);
        d.rd_hi    = req.rd && (req.addr == REG_NSHI);
        d.wr_lo    = req.wr && (req.addr == REG_NSLO);
        d.wr_hi    = req.wr && (req.addr == REG_NSHI);
        d.wr_trim  = req.wr && (req.addr == REG_TRIM);
        d.wr_ctrl  = req.wr && (req.addr == REG_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/ns_tc_frac.sv
module ns_tc_frac
    import ns_tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              clear,
    input  trim_t             trim,
    output logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic              borrow
);

    logic [FRAC_W:0]   up_ext;
    logic [FRAC_W:0]   dn_ext;
    logic [FRAC_W-1:0] frac_nxt;

    assign up_ext   = {1'b0, frac} + {1'b0, 1'b0, trim.mag};
    assign dn_ext   = {1'b0, frac} - {1'b0, 1'b0, trim.mag};
    assign carry    = !trim.neg && up_ext[FRAC_W];
    assign borrow   = trim.neg && dn_ext[FRAC_W];
    assign frac_nxt = trim.neg ? dn_ext[FRAC_W-1:0] : up_ext[FRAC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            frac <= '0;
        end else if (advance) begin
            frac <= frac_nxt;
        end
    end

    a_r2_frac_hold: assert property (@(posedge clk) disable iff (rst)
        !advance && !clear |=> $stable(frac));

    a_r3_zero_trim_hold: assert property (@(posedge clk) disable iff (rst)
        advance && !clear && (trim.mag == '0) |=> $stable(frac));

    a_r9_frac_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (frac == '0));

endmodule

// File: rtl/ns_tc_count.sv
module ns_tc_count #(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            carry,
    input  logic            borrow,
    input  logic            load,
    input  logic [NS_W-1:0] load_val,
    output logic [NS_W-1:0] ns
);

    localparam logic [NS_W-1:0] STEP_NOM = NS_W'(STEP_NS);
    localparam logic [NS_W-1:0] STEP_UP  = NS_W'(STEP_NS + 1);
    localparam logic [NS_W-1:0] STEP_DN  = NS_W'(STEP_NS - 1);

    logic [NS_W-1:0] step;

    always_comb begin
        if (carry) begin
            step = STEP_UP;
        end else if (borrow) begin
            step = STEP_DN;
        end else begin
            step = STEP_NOM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns <= '0;
        end else if (load) begin
            ns <= load_val;
        end else if (advance) begin
            ns <= ns + step;
        end
    end

    // Modular compare: covers the silent wrap at 2^NS_W.
    a_r3_step_window: assert property (@(posedge clk) disable iff (rst)
        advance && !load |=> (ns == $past(ns) + STEP_NOM)
                          || (ns == $past(ns) + STEP_UP)
                          || (ns == $past(ns) + STEP_DN));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !advance && !load |=> $stable(ns));

    a_r9_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (ns == $past(load_val)));

endmodule

// File: rtl/ns_tc_snap.sv
module ns_tc_snap #(
    parameter int NS_W = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic            free_i,
    input  logic [NS_W-1:0] ns,
    output logic            latched,
    output logic [NS_W-1:0] snap_ns
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= 1'b0;
            snap_ns <= '0;
        end else if (free_i) begin
            latched <= 1'b0;
        end else if (capture) begin
            latched <= 1'b1;
            snap_ns <= ns;
        end
    end

    a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
        latched && !capture && !free_i |=> $stable(snap_ns) && latched);

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        free_i |=> !latched);

endmodule

// File: rtl/ns_tc_regs.sv
module ns_tc_regs
    import ns_tc_pkg::*;
#(
    parameter int NS_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NS_W-1:0]   ns,
    input  logic [FRAC_W-1:0] frac,
    input  logic              latched,
    input  logic [NS_W-1:0]   snap_ns,
    output trim_t             trim,
    output logic              run,
    output logic              load,
    output logic [NS_W-1:0]   load_val,
    output logic              capture,
    output logic              free_o,
    output logic [DATA_W-1:0] rdata
);

    localparam int HI_W  = NS_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    bus_dec_t          dec;
    logic              halt;
    logic [DATA_W-1:0] staged_lo;
    logic [NS_W-1:0]   view_ns;
    logic [DATA_W-1:0] rd_word;

    assign dec      = decode_req(req);
    assign run      = !halt;
    assign load     = dec.wr_hi;
    assign load_val = {req.data[HI_W-1:0], staged_lo};
    assign capture  = dec.rd_subns;
    assign free_o   = dec.rd_hi || dec.wr_hi;
    assign view_ns  = latched ? snap_ns : ns;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt      <= 1'b1;
            trim      <= '0;
            staged_lo <= '0;
        end else begin
            if (dec.wr_ctrl) begin
                halt <= req.data[DATA_W-1];
            end
            if (dec.wr_trim) begin
                trim <= trim_t'(req.data);
            end
            if (dec.wr_lo) begin
                staged_lo <= req.data;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (req.addr)
            REG_SUBNS: rd_word = frac;
            REG_NSLO:  rd_word = view_ns[DATA_W-1:0];
            REG_NSHI:  rd_word = {{PAD_W{1'b0}}, view_ns[NS_W-1:DATA_W]};
            REG_TRIM:  rd_word = trim;
            REG_CTRL:  rd_word = {halt, {(DATA_W-1){1'b0}}};
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            rdata <= rd_word;
        end
    end

    a_r6_hi_pad_zero: assert property (@(posedge clk) disable iff (rst)
        req.rd && (req.addr == REG_NSHI) |=> (rdata[DATA_W-1:HI_W] == '0));

    a_r2_ctrl_pad_zero: assert property (@(posedge clk) disable iff (rst)
        req.rd && (req.addr == REG_CTRL) |=> (rdata[DATA_W-2:0] == '0));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        req.rd && (req.addr > REG_CTRL) |=> (rdata == '0));

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import ns_tc_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NS_W-1:0]   time_ns,
    output logic              time_run
);

    bus_req_t          req;
    trim_t             trim;
    logic              run;
    logic              load;
    logic [NS_W-1:0]   load_val;
    logic              capture;
    logic              free_v;
    logic              latched;
    logic [NS_W-1:0]   snap_ns;
    logic [FRAC_W-1:0] frac;
    logic              carry;
    logic              borrow;
    logic              tick;

    assign req      = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};
    assign tick     = run && !load;
    assign time_run = run;

    ns_tc_regs #(.NS_W(NS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .ns       (time_ns),
        .frac     (frac),
        .latched  (latched),
        .snap_ns  (snap_ns),
        .trim     (trim),
        .run      (run),
        .load     (load),
        .load_val (load_val),
        .capture  (capture),
        .free_o   (free_v),
        .rdata    (bus_rdata)
    );

    ns_tc_frac u_frac (
        .clk     (clk),
        .rst     (rst),
        .advance (tick),
        .clear   (load),
        .trim    (trim),
        .frac    (frac),
        .carry   (carry),
        .borrow  (borrow)
    );

    ns_tc_count #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_count (
        .clk      (clk),
        .rst      (rst),
        .advance  (tick),
        .carry    (carry),
        .borrow   (borrow),
        .load     (load),
        .load_val (load_val),
        .ns       (time_ns)
    );

    ns_tc_snap #(.NS_W(NS_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .free_i  (free_v),
        .ns      (time_ns),
        .latched (latched),
        .snap_ns (snap_ns)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (time_ns == '0) && !time_run);

endmodule

// File: tb/ns_time_counter_test.sv
module ns_time_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_wr = 1'b0;
    logic        b_rd = 1'b0;
    logic [2:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [39:0] time_ns;
    logic        time_run;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ns_time_counter uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (b_wr),
        .bus_rd    (b_rd),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (b_rdata),
        .time_ns   (time_ns),
        .time_run  (time_run)
    );

    // Reference model written from the requirements.
    logic [39:0] m_ns, m_snap;
    logic [31:0] m_frac, m_trim, m_stage, m_rdata;
    logic        m_halt, m_lat;

    always @(posedge clk) begin
        logic [31:0] o_trim;
        logic        o_halt, loaded;
        logic [32:0] acc;
        if (rst) begin
            m_ns = '0; m_frac = '0; m_trim = '0; m_stage = '0;
            m_halt = 1'b1; m_lat = 1'b0; m_snap = '0; m_rdata = '0;
        end else begin
            o_trim = m_trim;
            o_halt = m_halt;
            loaded = 1'b0;
            if (b_rd) begin
                case (b_addr)
                    3'd0: begin m_rdata = m_frac; m_lat = 1'b1; m_snap = m_ns; end
                    3'd1: m_rdata = m_lat ? m_snap[31:0] : m_ns[31:0];
                    3'd2: begin
                        m_rdata = {24'h0, m_lat ? m_snap[39:32] : m_ns[39:32]};
                        m_lat = 1'b0;
                    end
                    3'd3: m_rdata = m_trim;
                    3'd4: m_rdata = {m_halt, 31'h0};
                    default: m_rdata = '0;
                endcase
            end
            if (b_wr) begin
                case (b_addr)
                    3'd1: m_stage = b_wdata;
                    3'd2: begin
                        m_ns = {b_wdata[7:0], m_stage};
                        m_frac = '0; m_lat = 1'b0; loaded = 1'b1;
                    end
                    3'd3: m_trim = b_wdata;
                    3'd4: m_halt = b_wdata[31];
                    default: ;
                endcase
            end
            if (!loaded && !o_halt) begin
                if (!o_trim[31]) begin
                    acc = {1'b0, m_frac} + {2'b0, o_trim[30:0]};
                    m_ns = m_ns + 40'd8 + {39'd0, acc[32]};
                end else begin
                    acc = {1'b0, m_frac} - {2'b0, o_trim[30:0]};
                    m_ns = m_ns + 40'd8 - {39'd0, acc[32]};
                end
                m_frac = acc[31:0];
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d);
        b_wr = w; b_rd = r; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0; b_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        bus_op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        bus_op(1'b0, 1'b1, a, d);
        d = b_rdata;
    endtask

    task automatic load_time(input logic [39:0] t);
        wr_reg(3'd1, t[31:0]);
        wr_reg(3'd2, {24'h0, t[39:32]});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2;
        logic [39:0] t0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 count", 64'(time_ns), 64'd0);
        check("R1 run", 64'(time_run), 64'd0);
        rd_reg(3'd4, d); check("R1 ctrl", 64'(d), 64'h8000_0000);
        rd_reg(3'd3, d); check("R1 trim", 64'(d), 64'd0);
        rd_reg(3'd0, d); check("R1 subns", 64'(d), 64'd0);
        rd_reg(3'd2, d);

        // R2 halted after reset
        repeat (5) @(negedge clk);
        check("R2 halted", 64'(time_ns), 64'd0);

        // R3 nominal step
        wr_reg(3'd4, 32'h0);
        t0 = time_ns;
        @(negedge clk);
        check("R3 nominal step", 64'(time_ns - t0), 64'd8);
        repeat (10) @(negedge clk);
        check("R3 model", 64'(time_ns), 64'(m_ns));

        // R3 positive fraction: quarter ns per tick
        wr_reg(3'd3, 32'h4000_0000);
        load_time(40'd0);
        check("R9 load zero", 64'(time_ns), 64'd0);
        repeat (4) @(negedge clk);
        check("R3 carry cadence", 64'(time_ns), 64'd33);

        // R4 negative fraction
        wr_reg(3'd3, 32'hC000_0000);
        load_time(40'd0);
        repeat (4) @(negedge clk);
        check("R4 borrow cadence", 64'(time_ns), 64'd31);
        rd_reg(3'd3, d); check("R6 trim readback", 64'(d), 64'hC000_0000);

        // R5 wrap
        wr_reg(3'd3, 32'h0);
        load_time(40'hFF_FFFF_FFF8);
        check("R9 load top", 64'(time_ns), 64'hFF_FFFF_FFF8);
        @(negedge clk);
        check("R5 wrap", 64'(time_ns), 64'd0);
        @(negedge clk);
        check("R5 after wrap", 64'(time_ns), 64'd8);

        // R7 coherent read across a carry into the high word
        load_time(40'h12_FFFF_FFE0);
        t0 = time_ns;
        rd_reg(3'd0, d);
        repeat (6) @(negedge clk);
        rd_reg(3'd1, d);
        check("R7 frozen low", 64'(d), 64'(t0[31:0]));
        rd_reg(3'd2, d);
        check("R7 frozen high", 64'(d), 64'(t0[39:32]));
        // R8 live again
        t0 = time_ns;
        rd_reg(3'd1, d);
        check("R8 live low", 64'(d), 64'(t0[31:0]));
        rd_reg(3'd2, d);
        check("R8 live high", 64'(d), 64'h13);

        // R9 staged low write leaves the count alone
        t0 = time_ns;
        wr_reg(3'd1, 32'hDEAD_BEEF);
        check("R9 staged no effect", 64'(time_ns - t0), 64'd8);
        // R9 load releases a frozen view
        rd_reg(3'd0, d);
        wr_reg(3'd2, 32'h0000_0005);
        check("R9 staged commit", 64'(time_ns), 64'h05_DEAD_BEEF);
        repeat (3) @(negedge clk);
        t0 = time_ns;
        rd_reg(3'd1, d);
        check("R9 load frees view", 64'(d), 64'(t0[31:0]));

        // R6 high word padding
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd2, 32'hFFFF_FFAB);
        wr_reg(3'd4, 32'h8000_0000);
        rd_reg(3'd2, d);
        check("R6 high pad", 64'(d), 64'h0000_00AB);
        rd_reg(3'd4, d);
        check("R2 ctrl readback", 64'(d), 64'h8000_0000);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_reg(3'd4, d);
        check("R2 ctrl only bit31", 64'(d), 64'h8000_0000);

        // R2 halted hold with nonzero fraction
        wr_reg(3'd3, 32'h1234_5678);
        t0 = time_ns;
        rd_reg(3'd0, d);
        repeat (5) @(negedge clk);
        check("R2 count frozen", 64'(time_ns), 64'(t0));
        rd_reg(3'd0, d2);
        check("R2 frac frozen", 64'(d2), 64'(d));
        rd_reg(3'd2, d);
        // R9 load while halted
        load_time(40'h00_0000_0100);
        check("R9 halted load", 64'(time_ns), 64'h100);

        // R10 write to address 0 ignored, unmapped reads zero
        wr_reg(3'd0, 32'h1234);
        rd_reg(3'd0, d);
        check("R10 subns write ignored", 64'(d), 64'd0);
        check("R10 count untouched", 64'(time_ns), 64'h100);
        rd_reg(3'd6, d);
        check("R10 unmapped", 64'(d), 64'd0);

        // Random mix against the model
        wr_reg(3'd4, 32'h0);
        for (int i = 0; i < 3000; i++) begin
            int unsigned sel;
            logic was_rd;
            sel = $urandom % 16;
            was_rd = 1'b0;
            case (sel)
                0, 1: begin b_wr = 1'b1; b_addr = 3'd3; b_wdata = $urandom; end
                2, 3, 4: begin b_rd = 1'b1; b_addr = 3'($urandom % 8); was_rd = 1'b1; end
                5: begin b_wr = 1'b1; b_addr = 3'd4; b_wdata = {($urandom % 8) == 0, 31'h0}; end
                6: begin b_wr = 1'b1; b_addr = 3'd1; b_wdata = $urandom; end
                7: begin b_wr = 1'b1; b_addr = 3'd2; b_wdata = $urandom; end
                8: begin b_wr = 1'b1; b_addr = 3'd0; b_wdata = $urandom; end
                default: ;
            endcase
            @(negedge clk);
            b_wr = 1'b0; b_rd = 1'b0;
            check("R3 R4 random count", 64'(time_ns), 64'(m_ns));
            if (was_rd) check("R6 R7 random read", 64'(b_rdata), 64'(m_rdata));
        end

        finish_run();
    end

endmodule